// File: doc/BRIEF.md
# Sprite Table Copy Engine with Two-Bus Arbitration

This block fills the sprite attribute memory from a CPU-visible page of memory. Writing a page number to a start register launches a transfer: after one setup cycle, the engine copies a fixed number of bytes (160 by default), one per machine cycle in ascending order, from address `{page, index}` into sprite memory at `index`. A status output stays high for the setup cycle and every copy cycle.

The engine sits between the CPU and three memory paths. The shared external bus holds cartridge ROM and RAM and everything below $C000 except work RAM. A separate work-RAM bus serves $C000-$FDFF, using the low 13 address bits. An internal port serves I/O and high RAM at $FF00-$FFFF. During a copy, the engine takes over whichever of the two buses holds the source page. A CPU read on that bus gets the byte the engine is fetching in that cycle. The other bus and the internal port keep serving the CPU normally. The sprite region is closed to the CPU for as long as a transfer is active.

A write to the start register during a transfer abandons the current transfer and starts a new one from index 0 with the new page. The engine never holds back interrupts, so it has no connection to them.

Top module: `sdma_arbiter`

## Requirements
- R1: After reset the engine is idle: `dmaActive` is 0, no sprite write occurs, and a read of the start register ($FF46 by default) returns $00.
- R2: A CPU write to the start register is followed, on the next cycle, by one setup cycle. In that cycle `dmaActive` is 1 and `objWr` is 0. Then come `XFER_LEN` consecutive cycles, each asserting `objWr` with `objAddr` = k and the byte read from source address `{page, k}`, for k = 0 upward. `dmaActive` falls on the cycle after the last copy.
- R3: If the written page has its two top bits both set (page ≥ $C0), the source is read on the work-RAM bus at address `{page[4:0], k}`. Otherwise it is read on the external bus at `{page, k}`.
- R4: During copy cycles, a CPU read whose address falls on the source bus returns the byte being copied in that cycle. A CPU write to the source bus is dropped, so that bus's write strobe stays 0.
- R5: During copy cycles, CPU reads and writes on the bus that is not the source pass through unchanged and return that bus's data.
- R6: CPU accesses to $FF00-$FFFF, other than the start register, always reach the internal port with `ioAddr` equal to the low address byte. This holds during transfers too.
- R7: A read of the start register returns the last value written to it.
- R8: A start-register write during an active transfer is followed by a setup cycle and then a complete transfer from index 0 of the new page. The copy that was in progress in the cycle of the write still completes.
- R9: While `dmaActive` is 1, CPU reads in $FE00-$FE9F return $FF and CPU writes there never reach sprite memory. While idle, such accesses pass through to sprite memory at the low address byte.
- R10: CPU reads in $FEA0-$FEFF return $FF, and CPU accesses there never drive the sprite memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read request (opcode or data) |
| cpuWr | input | 1 | CPU write request |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Data returned to CPU |
| dmaActive | output | 1 | High during setup and copy cycles |
| extAddr | output | 16 | External bus address |
| extRd | output | 1 | External bus read strobe |
| extWr | output | 1 | External bus write strobe |
| extWdata | output | 8 | External bus write data |
| extRdata | input | 8 | External bus read data |
| wramAddr | output | 13 | Work-RAM bus address |
| wramRd | output | 1 | Work-RAM read strobe |
| wramWr | output | 1 | Work-RAM write strobe |
| wramWdata | output | 8 | Work-RAM write data |
| wramRdata | input | 8 | Work-RAM read data |
| ioAddr | output | 8 | Internal I/O / high-RAM address |
| ioRd | output | 1 | Internal port read strobe |
| ioWr | output | 1 | Internal port write strobe |
| ioWdata | output | 8 | Internal port write data |
| ioRdata | input | 8 | Internal port read data |
| objAddr | output | 8 | Sprite memory address |
| objRd | output | 1 | Sprite memory read strobe |
| objWr | output | 1 | Sprite memory write strobe |
| objWdata | output | 8 | Sprite memory write data |
| objRdata | input | 8 | Sprite memory read data |

## Verification
The embedded properties check the things that hold on every cycle. These are the setup-then-copy sequencing and the index stepping by one, the drop of `dmaActive` after the last index, and the start register holding its value between writes. The properties also check that the engine never writes the source bus and that sprite writes during a transfer come only from the engine. Finally, they check that every high-page access reaches the internal port. The values that actually land in sprite memory can only be shown by the bench's scenarios. So can the byte a conflicting CPU read receives, the restart from a new page partway through a copy, and the untouched sprite contents after a blocked CPU write. The bench sweeps source pages on both buses and mixes CPU traffic across all regions into the copy cycles.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_COPY  = 2'd2
  } dmaState_e;

  typedef enum logic [2:0] {
    RG_EXT  = 3'd0,
    RG_WRAM = 3'd1,
    RG_OBJ  = 3'd2,
    RG_VOID = 3'd3,
    RG_HIGH = 3'd4
  } region_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       active;
    logic       copying;
    logic       srcWram;
    logic [7:0] page;
    logic [7:0] idx;
  } dmaStrobe_t;

  localparam logic [7:0] OBJ_PAGE  = 8'hFE;
  localparam logic [7:0] HIGH_PAGE = 8'hFF;

endpackage

// File: rtl/sdma_ctl.sv
module sdma_ctl
  import sdma_pkg::*;
#(
  parameter int XFER_LEN = 160
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWr,
  input  logic [7:0] startData,
  output dmaStrobe_t ctl
);

  localparam logic [7:0] LAST_IDX = 8'(XFER_LEN - 1);

  dmaState_e  state;
  logic [7:0] idx;
  logic [7:0] page;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      page  <= '0;
    end else if (startWr) begin
      state <= ST_SETUP;
      page  <= startData;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_SETUP: begin
          state <= ST_COPY;
          idx   <= '0;
        end
        ST_COPY: begin
          if (idx == LAST_IDX) state <= ST_IDLE;
          else idx <= idx + 8'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.active  = (state != ST_IDLE);
    ctl.copying = (state == ST_COPY);
    ctl.srcWram = (page[7:6] == 2'b11);
    ctl.page    = page;
    ctl.idx     = idx;
  end

  // R2
  setup_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> (ctl.active && !ctl.copying && ctl.idx == 8'd0));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.copying && !startWr && ctl.idx != LAST_IDX) |=>
      (ctl.copying && ctl.idx == $past(ctl.idx) + 8'd1));

  // R2
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.copying && !startWr && ctl.idx == LAST_IDX) |=> !ctl.active);

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startWr |=> (ctl.page == $past(ctl.page)));

endmodule

// File: rtl/sdma_path.sv
module sdma_path
  import sdma_pkg::*;
#(
  parameter int          XFER_LEN   = 160,
  parameter logic [15:0] START_ADDR = 16'hFF46
) (
  input  logic        clk,
  input  logic        rstN,
  input  dmaStrobe_t  ctl,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic [7:0]  cpuWdata,
  output logic [7:0]  cpuRdata,
  output logic        startWr,
  output logic [15:0] extAddr,
  output logic        extRd,
  output logic        extWr,
  output logic [7:0]  extWdata,
  input  logic [7:0]  extRdata,
  output logic [12:0] wramAddr,
  output logic        wramRd,
  output logic        wramWr,
  output logic [7:0]  wramWdata,
  input  logic [7:0]  wramRdata,
  output logic [7:0]  ioAddr,
  output logic        ioRd,
  output logic        ioWr,
  output logic [7:0]  ioWdata,
  input  logic [7:0]  ioRdata,
  output logic [7:0]  objAddr,
  output logic        objRd,
  output logic        objWr,
  output logic [7:0]  objWdata,
  input  logic [7:0]  objRdata
);

  localparam logic [8:0] OBJ_END = 9'(XFER_LEN);

  region_e    region;
  logic       isStart;
  logic       dmaExt;
  logic       dmaWram;
  logic [7:0] dmaByte;

  always_comb begin
    if (cpuAddr[15:8] == HIGH_PAGE)
      region = RG_HIGH;
    else if (cpuAddr[15:8] == OBJ_PAGE)
      region = ({1'b0, cpuAddr[7:0]} < OBJ_END) ? RG_OBJ : RG_VOID;
    else if (cpuAddr[15:14] == 2'b11)
      region = RG_WRAM;
    else
      region = RG_EXT;
  end

  assign isStart = (cpuAddr == START_ADDR);
  assign startWr = cpuWr && isStart;
  assign dmaExt  = ctl.copying && !ctl.srcWram;
  assign dmaWram = ctl.copying && ctl.srcWram;
  assign dmaByte = ctl.srcWram ? wramRdata : extRdata;

  // external bus: engine owns it while copying from it
  always_comb begin
    extWdata = cpuWdata;
    if (dmaExt) begin
      extAddr = {ctl.page, ctl.idx};
      extRd   = 1'b1;
      extWr   = 1'b0;
    end else begin
      extAddr = cpuAddr;
      extRd   = cpuRd && (region == RG_EXT);
      extWr   = cpuWr && (region == RG_EXT);
    end
  end

  // work-RAM bus
  always_comb begin
    wramWdata = cpuWdata;
    if (dmaWram) begin
      wramAddr = {ctl.page[4:0], ctl.idx};
      wramRd   = 1'b1;
      wramWr   = 1'b0;
    end else begin
      wramAddr = cpuAddr[12:0];
      wramRd   = cpuRd && (region == RG_WRAM);
      wramWr   = cpuWr && (region == RG_WRAM);
    end
  end

  // internal I/O and high RAM: always open except the start register
  always_comb begin
    ioAddr  = cpuAddr[7:0];
    ioWdata = cpuWdata;
    ioRd    = cpuRd && (region == RG_HIGH) && !isStart;
    ioWr    = cpuWr && (region == RG_HIGH) && !isStart;
  end

  // sprite memory: engine during copy, closed during setup, CPU when idle
  always_comb begin
    if (ctl.copying) begin
      objAddr  = ctl.idx;
      objRd    = 1'b0;
      objWr    = 1'b1;
      objWdata = dmaByte;
    end else begin
      objAddr  = cpuAddr[7:0];
      objRd    = cpuRd && (region == RG_OBJ) && !ctl.active;
      objWr    = cpuWr && (region == RG_OBJ) && !ctl.active;
      objWdata = cpuWdata;
    end
  end

  always_comb begin
    unique case (region)
      RG_EXT:  cpuRdata = extRdata;
      RG_WRAM: cpuRdata = wramRdata;
      RG_OBJ:  cpuRdata = ctl.active ? 8'hFF : objRdata;
      RG_HIGH: cpuRdata = isStart ? ctl.page : ioRdata;
      default: cpuRdata = 8'hFF;
    endcase
  end

  // R4
  no_src_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copying |-> (ctl.srcWram ? !wramWr : !extWr));

  // R9
  obj_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (objWr && ctl.active) |-> (ctl.copying && objAddr == ctl.idx));

  // R6
  io_reach_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuRd || cpuWr) && cpuAddr[15:8] == 8'hFF && cpuAddr != START_ADDR)
      |-> ((ioRd || ioWr) && ioAddr == cpuAddr[7:0]));

  // R10
  void_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:8] == 8'hFE && cpuAddr[7:0] >= 8'(XFER_LEN) && !ctl.copying)
      |-> (!objWr && !objRd));

endmodule

// File: rtl/sdma_arbiter.sv
module sdma_arbiter
  import sdma_pkg::*;
#(
  parameter int          XFER_LEN   = 160,
  parameter logic [15:0] START_ADDR = 16'hFF46
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic [7:0]  cpuWdata,
  output logic [7:0]  cpuRdata,
  output logic        dmaActive,
  output logic [15:0] extAddr,
  output logic        extRd,
  output logic        extWr,
  output logic [7:0]  extWdata,
  input  logic [7:0]  extRdata,
  output logic [12:0] wramAddr,
  output logic        wramRd,
  output logic        wramWr,
  output logic [7:0]  wramWdata,
  input  logic [7:0]  wramRdata,
  output logic [7:0]  ioAddr,
  output logic        ioRd,
  output logic        ioWr,
  output logic [7:0]  ioWdata,
  input  logic [7:0]  ioRdata,
  output logic [7:0]  objAddr,
  output logic        objRd,
  output logic        objWr,
  output logic [7:0]  objWdata,
  input  logic [7:0]  objRdata
);

  dmaStrobe_t ctl;
  logic       startWr;

  sdma_ctl #(.XFER_LEN(XFER_LEN)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startWr   (startWr),
    .startData (cpuWdata),
    .ctl       (ctl)
  );

  sdma_path #(.XFER_LEN(XFER_LEN), .START_ADDR(START_ADDR)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cpuAddr   (cpuAddr),
    .cpuRd     (cpuRd),
    .cpuWr     (cpuWr),
    .cpuWdata  (cpuWdata),
    .cpuRdata  (cpuRdata),
    .startWr   (startWr),
    .extAddr   (extAddr),
    .extRd     (extRd),
    .extWr     (extWr),
    .extWdata  (extWdata),
    .extRdata  (extRdata),
    .wramAddr  (wramAddr),
    .wramRd    (wramRd),
    .wramWr    (wramWr),
    .wramWdata (wramWdata),
    .wramRdata (wramRdata),
    .ioAddr    (ioAddr),
    .ioRd      (ioRd),
    .ioWr      (ioWr),
    .ioWdata   (ioWdata),
    .ioRdata   (ioRdata),
    .objAddr   (objAddr),
    .objRd     (objRd),
    .objWr     (objWr),
    .objWdata  (objWdata),
    .objRdata  (objRdata)
  );

  assign dmaActive = ctl.active;

endmodule

// File: tb/tb_sdma_arbiter.sv
module tb_sdma_arbiter;

  localparam int          LEN   = 160;
  localparam logic [15:0] START = 16'hFF46;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cpuAddr;
  logic        cpuRd, cpuWr;
  logic [7:0]  cpuWdata, cpuRdata;
  logic        dmaActive;
  logic [15:0] extAddr;
  logic        extRd, extWr;
  logic [7:0]  extWdata, extRdata;
  logic [12:0] wramAddr;
  logic        wramRd, wramWr;
  logic [7:0]  wramWdata, wramRdata;
  logic [7:0]  ioAddr;
  logic        ioRd, ioWr;
  logic [7:0]  ioWdata, ioRdata;
  logic [7:0]  objAddr;
  logic        objRd, objWr;
  logic [7:0]  objWdata, objRdata;

  logic [7:0] oam [256];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] patExt(logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd5) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] patW(logic [12:0] a);
    return a[7:0] + ({3'b000, a[12:8]} * 8'd7) + 8'h11;
  endfunction

  function automatic logic [7:0] expByte(logic [7:0] page, logic [7:0] k);
    if (page[7:6] == 2'b11) return patW({page[4:0], k});
    return patExt({page, k});
  endfunction

  assign extRdata  = patExt(extAddr);
  assign wramRdata = patW(wramAddr);
  assign ioRdata   = ~ioAddr;
  assign objRdata  = oam[objAddr];

  always @(posedge clk) if (objWr) oam[objAddr] <= objWdata;

  sdma_arbiter #(.XFER_LEN(LEN), .START_ADDR(START)) dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] a, logic rd, logic wr, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuWdata = d;
    #1;
  endtask

  task automatic idle();
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  // setup cycle, full copy and the fall of the flag
  task automatic copyLoop(logic [7:0] page);
    idle();
    chk("R2 setup active", 16'(dmaActive), 16'd1);
    chk("R2 setup no write", 16'(objWr), 16'd0);
    for (int k = 0; k < LEN; k++) begin
      idle();
      chk("R2 copy strobe", 16'(objWr), 16'd1);
      chk("R2 copy index", 16'(objAddr), 16'(k));
      chk("R3 copy byte", 16'(objWdata), 16'(expByte(page, 8'(k))));
    end
    idle();
    chk("R2 flag falls", 16'(dmaActive), 16'd0);
    for (int k = 0; k < LEN; k++)
      chk("R2 sprite content", 16'(oam[k]), 16'(expByte(page, 8'(k))));
  endtask

  task automatic runXfer(logic [7:0] page);
    drive(START, 1'b0, 1'b1, page);
    copyLoop(page);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) oam[i] = 8'h00;
    rstN = 1'b0;
    cpuAddr = START; cpuRd = 1'b1; cpuWr = 1'b0; cpuWdata = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 idle", 16'(dmaActive), 16'd0);
    chk("R1 start reg", 16'(cpuRdata), 16'h00);
    chk("R1 no sprite write", 16'(objWr), 16'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 R3: sweep of source pages on both buses
    runXfer(8'h00);
    runXfer(8'h3A);
    runXfer(8'h7F);
    runXfer(8'h9C);
    runXfer(8'hA5);
    runXfer(8'hC0);
    runXfer(8'hD7);
    runXfer(8'hFF);

    // R7 readback
    drive(START, 1'b1, 1'b0, 8'h00);
    chk("R7 readback", 16'(cpuRdata), 16'h00FF);

    // work-RAM source with CPU traffic
    drive(START, 1'b0, 1'b1, 8'hC2);
    drive(16'hFE20, 1'b1, 1'b0, 8'h00);
    chk("R9 setup read", 16'(cpuRdata), 16'h00FF);
    for (int k = 0; k < LEN; k++) begin
      case (k % 5)
        0: begin
          drive(16'h1234, 1'b1, 1'b0, 8'h00);
          chk("R5 ext read", 16'(cpuRdata), 16'(patExt(16'h1234)));
        end
        1: begin
          drive(16'hD555, 1'b1, 1'b0, 8'h00);
          chk("R4 conflict byte", 16'(cpuRdata), 16'(expByte(8'hC2, 8'(k))));
        end
        2: begin
          drive(16'hFF80, 1'b1, 1'b0, 8'h00);
          chk("R6 io read", 16'(cpuRdata), 16'h007F);
        end
        3: begin
          drive(16'hC010, 1'b0, 1'b1, 8'hAA);
          chk("R4 write dropped", 16'(wramWr), 16'd0);
        end
        default: begin
          drive(16'hFE10, (k % 2) == 0, (k % 2) == 1, 8'h55);
          if ((k % 2) == 0) chk("R9 busy read", 16'(cpuRdata), 16'h00FF);
          chk("R9 busy write", 16'(objAddr), 16'(k));
        end
      endcase
      chk("R2 copy under load", 16'(objWdata), 16'(expByte(8'hC2, 8'(k))));
    end
    idle();
    chk("R9 sprite kept", 16'(oam[16]), 16'(expByte(8'hC2, 8'h10)));

    // external source with CPU traffic
    drive(START, 1'b0, 1'b1, 8'h41);
    idle();
    for (int k = 0; k < LEN; k++) begin
      if (k % 3 == 0) begin
        drive(16'h0150, 1'b1, 1'b0, 8'h00);
        chk("R4 ext conflict", 16'(cpuRdata), 16'(patExt({8'h41, 8'(k)})));
      end else if (k % 3 == 1) begin
        drive(16'hC123, 1'b1, 1'b0, 8'h00);
        chk("R5 wram read", 16'(cpuRdata), 16'(patW(13'h0123)));
      end else begin
        drive(16'h2100, 1'b0, 1'b1, 8'h09);
        chk("R4 ext write dropped", 16'(extWr), 16'd0);
      end
    end
    idle();
    chk("R2 ext done", 16'(dmaActive), 16'd0);

    // idle sprite access and void region
    drive(16'hFE20, 1'b0, 1'b1, 8'h77);
    chk("R9 idle write", 16'({objWr, objAddr}), 16'h0120);
    drive(16'hFE20, 1'b1, 1'b0, 8'h00);
    chk("R9 idle read", 16'(cpuRdata), 16'h0077);
    drive(16'hFEA5, 1'b1, 1'b0, 8'h00);
    chk("R10 void read", 16'(cpuRdata), 16'h00FF);
    chk("R10 void rd strobe", 16'(objRd), 16'd0);
    drive(16'hFEB0, 1'b0, 1'b1, 8'h33);
    chk("R10 void write", 16'(objWr), 16'd0);
    drive(16'hFF05, 1'b0, 1'b1, 8'h12);
    chk("R6 io write", 16'({ioWr, ioAddr}), 16'h0105);

    // R8 restart mid-transfer
    drive(START, 1'b0, 1'b1, 8'h20);
    idle();
    for (int k = 0; k < 10; k++) begin
      idle();
      chk("R8 first copy", 16'(objAddr), 16'(k));
    end
    drive(START, 1'b0, 1'b1, 8'h40);
    chk("R8 write-cycle copy", 16'(objAddr), 16'd10);
    copyLoop(8'h40);
    drive(START, 1'b1, 1'b0, 8'h00);
    chk("R7 readback new", 16'(cpuRdata), 16'h0040);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule